// File: doc/BRIEF.md
# DSD Stream Loss Detector with Idle-Pattern Fill

This block sits in the one-bit audio path between a stream source and the analog reconstruction filter. It runs from the audio master clock, nominally 11.2896 MHz or 12.288 MHz, and takes one left and one right DSD bit on every master-clock edge. A free-running prescaler divides the master clock by `DIV` (two by default). A saturating timeout counter advances once per divided period and restarts whenever the registered left bit changes level.

When the counter reaches `LIMIT` (196 by default, about 30 us) the left stream counts as lost. Both outputs then carry a square wave whose period is `DIV` master clocks, and the fill status output is raised. After the low-pass filter, that square wave settles to the zero analog level. The next left transition switches both outputs straight back to the live data, with no hold-off.

The DSD bits arrive at a fixed rate from the master clock, so the data path has no valid/ready handshake. An input bit is taken on every edge, an output bit is produced on every edge, and back-pressure cannot occur. A downstream stage that cannot take a bit on each edge cannot use this block.

Top module: `dsd_gap_filler`

## Requirements
- R1: During reset and right after it, `fill_o` is 1, and the block sends the fill pattern until the first left transition is sampled.
- R2: While the stream is live, `dsd_l_o` after clock edge k+1 equals `dsd_l_i` as sampled at edge k, and `fill_o` is 0.
- R3: The right channel has the same latency as the left, so `dsd_r_o` after edge k+1 equals `dsd_r_i` sampled at edge k while live.
- R4: The last left transition is sampled at edge k. `fill_o` is still 0 after edge k+2+(LIMIT-1)*DIV and is 1 after edge k+2+LIMIT*DIV. This holds whether the left input rests high or low.
- R5: While `fill_o` is 1, `dsd_l_o` equals `dsd_r_o`. The pattern is high for DIV/2 clocks and low for DIV/2 clocks, so with DIV=2 it toggles on every clock.
- R6: The timeout count saturates at LIMIT, so `fill_o` stays 1 for as long as the left input stays idle.
- R7: A left transition sampled at edge k clears `fill_o` after edge k+1, and at the same edge `dsd_l_o` shows the new level.
- R8: Transitions on the right input neither restart the timeout nor end the fill.
- R9: Rising and falling left transitions both restart the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Audio master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dsd_l_i | input | 1 | Left DSD bit, one per clock |
| dsd_r_i | input | 1 | Right DSD bit, one per clock |
| dsd_l_o | output | 1 | Left output, live data or fill pattern |
| dsd_r_o | output | 1 | Right output, live data or fill pattern |
| fill_o | output | 1 | High while the fill pattern is selected |

## Verification
The data path passes through two registers, so an input bit driven before edge k shows at the outputs after edge k+1. The bench drives at falling edges and compares against the value it drove two falling edges earlier. A resume is due one edge after the transition is sampled. Loss is due between edges k+3+(LIMIT-1)*DIV and k+2+LIMIT*DIV, because the prescaler phase is free. The bench therefore checks once just before that window, expecting live data, and once just after it, expecting fill.

// File: rtl/dsd_gap_pkg.sv
package dsd_gap_pkg;
  localparam int unsigned DEF_LIMIT = 196;
  localparam int unsigned DEF_DIV   = 2;
endpackage

// File: rtl/dgf_edge_watch.sv
module dgf_edge_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_i,
  input  logic r_i,
  output logic l_q_o,
  output logic r_q_o,
  output logic edge_o
);
  logic l_prev;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      l_q_o  <= 1'b0;
      r_q_o  <= 1'b0;
      l_prev <= 1'b0;
    end else begin
      l_q_o  <= l_i;
      r_q_o  <= r_i;
      l_prev <= l_q_o;
    end
  end

  // either polarity restarts the timeout
  assign edge_o = l_q_o ^ l_prev;
endmodule

// File: rtl/dgf_prescale.sv
module dgf_prescale #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic phase_o
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] HALF = PW'(DIV / 2);

  logic [PW-1:0] pre;

  generate
    if (DIV == 2) begin : g_toggle
      always_ff @(posedge clk_i) begin
        if (!rst_ni) pre <= '0;
        else         pre <= ~pre;
      end
    end else begin : g_count
      always_ff @(posedge clk_i) begin
        if (!rst_ni)          pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                  pre <= pre + 1'b1;
      end
    end
  endgenerate

  assign tick_o  = (pre == LAST);
  assign phase_o = (pre < HALF);
endmodule

// File: rtl/dgf_timeout.sv
module dgf_timeout #(
  parameter int unsigned LIMIT = 196,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          lost_o
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                    cnt_o <= TOP;
    else if (restart_i)             cnt_o <= '0;
    else if (tick_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  assign lost_o = (cnt_o == TOP);
endmodule

// File: rtl/dsd_gap_filler.sv
module dsd_gap_filler #(
  parameter int unsigned LIMIT = dsd_gap_pkg::DEF_LIMIT,
  parameter int unsigned DIV   = dsd_gap_pkg::DEF_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dsd_l_i,
  input  logic dsd_r_i,
  output logic dsd_l_o,
  output logic dsd_r_o,
  output logic fill_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic          l_q, r_q, l_edge, tick, phase, lost, sel;
  logic [CW-1:0] tmo_cnt;

  dgf_edge_watch u_in (
    .clk_i (clk_i), .rst_ni (rst_ni), .l_i (dsd_l_i), .r_i (dsd_r_i),
    .l_q_o (l_q), .r_q_o (r_q), .edge_o (l_edge)
  );

  dgf_prescale #(.DIV(DIV)) u_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick), .phase_o (phase)
  );

  dgf_timeout #(.LIMIT(LIMIT)) u_tmo (
    .clk_i (clk_i), .rst_ni (rst_ni), .restart_i (l_edge), .tick_i (tick),
    .cnt_o (tmo_cnt), .lost_o (lost)
  );

  // a fresh transition overrides the saturated count in the same cycle
  assign sel = lost & ~l_edge;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      dsd_l_o <= 1'b0;
      dsd_r_o <= 1'b0;
      fill_o  <= 1'b1;
    end else begin
      dsd_l_o <= sel ? phase : l_q;
      dsd_r_o <= sel ? phase : r_q;
      fill_o  <= sel;
    end
  end
endmodule

// File: rtl/dsd_gap_filler_chk.sv
module dsd_gap_filler_chk #(
  parameter int unsigned LIMIT = 196,
  parameter int unsigned CW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dsd_l_i,
  input logic          dsd_l_o,
  input logic          dsd_r_o,
  input logic          fill_o,
  input logic          l_edge,
  input logic [CW-1:0] tmo_cnt
);
  logic [1:0] seen;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)         seen <= '0;
    else if (seen != 2'd3) seen <= seen + 1'b1;
  end

  a_r2_live_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd3 && !fill_o) |-> dsd_l_o == $past(dsd_l_i, 2));

  a_r5_pattern_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |-> dsd_l_o == dsd_r_o);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_cnt <= CW'(LIMIT));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o && !l_edge) |=> fill_o);

  a_r7_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_edge |=> !fill_o);
endmodule

bind dsd_gap_filler dsd_gap_filler_chk #(.LIMIT(LIMIT), .CW(CW)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .dsd_l_i (dsd_l_i),
  .dsd_l_o (dsd_l_o), .dsd_r_o (dsd_r_o), .fill_o (fill_o),
  .l_edge (l_edge), .tmo_cnt (tmo_cnt)
);

// File: tb/tb_dsd_gap_filler.sv
`timescale 1ns/1ps
module tb_dsd_gap_filler;
  localparam int LIMIT = 196;
  localparam int DIV   = 2;

  logic clk = 1'b0, rst_n = 1'b0, l_in = 1'b0, r_in = 1'b0;
  logic l_out, r_out, fill;
  int   nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  dsd_gap_filler #(.LIMIT(LIMIT), .DIV(DIV)) dut (
    .clk_i (clk), .rst_ni (rst_n), .dsd_l_i (l_in), .dsd_r_i (r_in),
    .dsd_l_o (l_out), .dsd_r_o (r_out), .fill_o (fill)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R5: two consecutive samples while filling
  task automatic check_pattern(input string req);
    logic a;
    check(fill == 1'b1, req, fill, 1);
    check(l_out == r_out, "R5 equal", r_out, l_out);
    a = l_out;
    negs(1);
    check(l_out == ~a, "R5 toggle", l_out, ~a);
    check(l_out == r_out, "R5 equal", r_out, l_out);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; l_in = 1'b0; r_in = 1'b0;
    negs(3);
    check(fill == 1'b1, "R1 in reset", fill, 1);
    rst_n = 1'b1;
    negs(3);
    check_pattern("R1 after reset");
  endtask

  task automatic t_live(input logic [31:0] wl, input logic [31:0] wr);
    logic hl [0:33];
    logic hr [0:33];
    for (int i = 0; i < 34; i++) begin
      if (i >= 2) begin
        check(fill == 1'b0, "R2 fill low", fill, 0);
        check(l_out == hl[i-2], "R2 left data", l_out, hl[i-2]);
        check(r_out == hr[i-2], "R3 right data", r_out, hr[i-2]);
      end
      if (i < 32) begin
        hl[i] = (i == 0) ? ~l_in : wl[i];
        hr[i] = wr[i];
      end else begin
        hl[i] = hl[i-1];
        hr[i] = hr[i-1];
      end
      l_in = hl[i]; r_in = hr[i];
      negs(1);
    end
  endtask

  task automatic t_timeout(input logic level);
    if (l_in == level) begin l_in = ~level; negs(1); end
    l_in = level;
    negs(3 + (LIMIT - 1) * DIV);
    check(fill == 1'b0, level ? "R4 high still live" : "R4 low still live", fill, 0);
    check(l_out == level, "R4 data held", l_out, level);
    negs(DIV);
    check(fill == 1'b1, level ? "R4 high lost" : "R4 low lost", fill, 1);
    check_pattern("R5 after timeout");
  endtask

  task automatic t_saturate();
    negs(3 * LIMIT * DIV);
    check_pattern("R6 saturated");
  endtask

  task automatic t_right_ignored();
    for (int i = 0; i < 20; i++) begin
      r_in = ~r_in;
      negs(1);
      check(fill == 1'b1, "R8 right toggles", fill, 1);
    end
    check_pattern("R8 pattern kept");
  endtask

  task automatic t_resume(input string req);
    logic nv;
    nv = ~l_in;
    l_in = nv;
    negs(2);
    check(fill == 1'b0, req, fill, 0);
    check(l_out == nv, "R7 new level", l_out, nv);
  endtask

  initial begin
    t_reset();
    t_live(32'hA5C3_0F96, 32'h3C5A_F00F);
    t_timeout(1'b1);
    t_saturate();
    t_right_ignored();
    t_resume("R9 falling restart");
    t_live(32'h0123_FEDC, 32'hFFFF_0000);
    t_timeout(1'b0);
    t_resume("R9 rising restart");
    t_resume("R7 resume");
    t_timeout(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule